// File: doc/BRIEF.md
# Trace Port Test Pattern Generator

This block sits in front of a parallel trace data output bus. In normal operation it passes the incoming trace word straight to the bus. When a start strobe arrives, it replaces the trace data with diagnostic patterns that exercise the board wiring and pad drivers. The patterns are walking ones, walking zeros, an alternating odd/even bit pattern and an all-high/all-low toggle. Every pattern starts at bit 0 and covers only the bits of the port width chosen at run time. Bits above that width stay low while a test runs.

A pattern-enable mask picks which patterns run. Each enabled pattern is held for a programmed number of cycles, and the enabled patterns run one after another. After the last one the block goes back to passing trace data. If the continuous flag is set, the block instead loops back to the first enabled pattern. A flag tells the rest of the trace path that a test is under way.

Top module: `tpg_trace_pattern`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `test_active_o` is low and `data_o` equals `trace_i`.
- R2: While no test runs, `data_o` follows `trace_i` combinationally on every cycle.
- R3: Walking ones (enable bit 0) drives a single high bit. It starts at bit 0 and moves up one position per cycle. After bit W-1 it wraps to bit 0, where W is the active width.
- R4: Walking zeros (enable bit 1) drives all W active bits high except one low bit. The low bit starts at bit 0, moves up one position per cycle and wraps after bit W-1.
- R5: The odd/even pattern (enable bit 2) first drives the odd-numbered active bits high (binary ...1010). On the next cycle it drives the even-numbered active bits high (...0101), and it keeps alternating every cycle.
- R6: The level-toggle pattern (enable bit 3) drives all W active bits high on its first cycle and all low on the next, and keeps alternating every cycle.
- R7: The active width W comes from `width_sel_i`, which gives the number of active bits. A value of 0 is treated as 1 and a value above DATA_W is treated as DATA_W. The width is captured at start and held for the whole run. Bits at index W and above read 0 throughout a test.
- R8: Enabled patterns run in the order walking ones, walking zeros, odd/even, level toggle, and disabled patterns are skipped with no gap cycles. Each pattern lasts `repeat_i` cycles, with 0 treated as 1. The repeat count and mask are captured at start, and each pattern restarts from its initial state on entry.
- R9: The first pattern word appears in the cycle after the start strobe is sampled. After the final cycle of the last enabled pattern, `test_active_o` drops and `data_o` returns to `trace_i`.
- R10: If `cont_i` is high in the final cycle of a pass, the next cycle restarts at the first enabled pattern. Clearing `cont_i` lets the current pass finish and then ends the test.
- R11: A start strobe with an all-zero enable mask leaves the block in normal mode.
- R12: A start strobe, or any change of width, mask or repeat count, during a running test has no effect on that test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| pat_en_i | input | 4 | Pattern enables: bit0 walking ones, bit1 walking zeros, bit2 odd/even, bit3 level toggle |
| width_sel_i | input | $clog2(DATA_W+1) | Number of active data bits |
| repeat_i | input | RPT_W | Cycles per pattern (0 acts as 1) |
| cont_i | input | 1 | Loop the enabled patterns continuously |
| trace_i | input | DATA_W | Normal trace data word |
| data_o | output | DATA_W | Trace data bus |
| test_active_o | output | 1 | High while a test pattern is driven |

## Verification
Some properties are checked by assertions on every cycle. While a test runs, bits above the active width stay zero, and walking ones keeps exactly one bit set. Walking zeros keeps exactly W-1 bits set, the odd/even pattern never has two adjacent bits high, and the level toggle is either empty or full. The current pattern is always an enabled one, the repeat counter stays in range, and the captured width and mask never change mid-run. Other behaviour can only be shown by the bench's reference model, compared against the outputs on every clock. This covers the exact order and duration of the patterns, the wrap point of the walking bit, where each alternating pattern starts, the handover back to trace data, the continuous loop and its exit, the clamping of width and repeat count, and that strobes issued mid-run are ignored.

// File: rtl/tpg_pkg.sv
// Package: shared pattern codes and the helper that finds the next enabled
// pattern. Assumes exactly four patterns, visited in index order.
package tpg_pkg;

    localparam int NUM_PAT = 4;

    typedef enum logic [1:0] {
        PAT_WALK1  = 2'd0,
        PAT_WALK0  = 2'd1,
        PAT_ODDEVN = 2'd2,
        PAT_LEVEL  = 2'd3
    } pat_e;

    // Lowest set bit of m at index >= lo; result is {found, index}.
    function automatic logic [2:0] first_set(input logic [NUM_PAT-1:0] m, input int lo);
        first_set = 3'b000;
        for (int i = NUM_PAT - 1; i >= 0; i--) begin
            if (m[i] && i >= lo) first_set = {1'b1, 2'(i)};
        end
    endfunction

endpackage

// File: rtl/tpg_seq.sv
// Sequencer: captures mask, width and repeat count at start, steps through
// the enabled patterns, and keeps the per-pattern position and phase.
// Assumes start is only honoured while idle; cont_i is read live at the end of a pass.
module tpg_seq
    import tpg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int RPT_W  = 8,
    parameter int WSEL_W = $clog2(DATA_W + 1),
    parameter int POS_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [NUM_PAT-1:0] en_mask,
    input  logic [WSEL_W-1:0]  width_sel,
    input  logic [RPT_W-1:0]   rpt,
    input  logic               cont,
    output logic               busy,
    output pat_e               pat,
    output logic [POS_W-1:0]   pos,
    output logic               phase,
    output logic [WSEL_W-1:0]  width
);

    logic [NUM_PAT-1:0] mask_q;
    logic [RPT_W-1:0]   rpt_q;
    logic [RPT_W-1:0]   cnt;
    logic [1:0]         cur;
    logic [WSEL_W-1:0]  w_q;
    logic [WSEL_W-1:0]  w_clamp;
    logic [RPT_W-1:0]   rpt_eff;
    logic [2:0]         nxt_sel;
    logic [2:0]         first_new;
    logic [2:0]         first_loop;
    logic               last_cyc;

    // Clamp the requested width and repeat count to legal values.
    always_comb begin
        if (width_sel == '0)                         w_clamp = WSEL_W'(1);
        else if (width_sel > WSEL_W'(DATA_W))        w_clamp = WSEL_W'(DATA_W);
        else                                         w_clamp = width_sel;
        rpt_eff = (rpt == '0) ? RPT_W'(1) : rpt;
    end

    // Choose the pattern for the start, the next step and the loop-around.
    always_comb begin
        first_new  = first_set(en_mask, 0);
        first_loop = first_set(mask_q, 0);
        nxt_sel    = first_set(mask_q, int'(cur) + 1);
        last_cyc   = (cnt == rpt_q - 1'b1);
    end

    // Main sequencing register: idle/run, pattern index, counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cur    <= 2'd0;
            cnt    <= '0;
            pos    <= '0;
            phase  <= 1'b0;
            mask_q <= '0;
            rpt_q  <= RPT_W'(1);
            w_q    <= WSEL_W'(1);
        end else if (!busy) begin
            if (start && first_new[2]) begin
                busy   <= 1'b1;
                mask_q <= en_mask;
                rpt_q  <= rpt_eff;
                w_q    <= w_clamp;
                cur    <= first_new[1:0];
                cnt    <= '0;
                pos    <= '0;
                phase  <= 1'b0;
            end
        end else if (last_cyc) begin
            cnt   <= '0;
            pos   <= '0;
            phase <= 1'b0;
            if (nxt_sel[2])        cur  <= nxt_sel[1:0];
            else if (cont)         cur  <= first_loop[1:0];
            else                   busy <= 1'b0;
        end else begin
            cnt   <= cnt + 1'b1;
            phase <= ~phase;
            pos   <= (int'(pos) == int'(w_q) - 1) ? '0 : pos + 1'b1;
        end
    end

    assign pat   = pat_e'(cur);
    assign width = w_q;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> cnt < rpt_q);                                              // R8
    AST_PAT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> mask_q[cur]);                                              // R8
    AST_EMPTY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && en_mask == '0) |=> !busy);                       // R11
    AST_PARAMS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(w_q) && $stable(mask_q) && $stable(rpt_q))); // R12
    AST_POS_IN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> int'(pos) < int'(w_q));                                    // R3

endmodule

// File: rtl/tpg_pat.sv
// Pattern word builder: turns pattern code, walking position, alternation
// phase and active width into the bus word. Assumes pos < width <= DATA_W.
module tpg_pat
    import tpg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WSEL_W = $clog2(DATA_W + 1),
    parameter int POS_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  pat_e              pat,
    input  logic [POS_W-1:0]  pos,
    input  logic              phase,
    input  logic [WSEL_W-1:0] width,
    output logic [DATA_W-1:0] word
);

    logic [DATA_W-1:0] act_mask;
    logic [DATA_W-1:0] odd_bits;
    logic [DATA_W-1:0] one_hot;

    // Build the active-width mask, odd-bit mask and walking one-hot.
    always_comb begin
        one_hot = '0;
        for (int i = 0; i < DATA_W; i++) begin
            act_mask[i] = (i < int'(width));
            odd_bits[i] = (i % 2) == 1;
            if (i == int'(pos)) one_hot[i] = 1'b1;
        end
    end

    // Select the word for the current pattern.
    always_comb begin
        unique case (pat)
            PAT_WALK1:  word = one_hot & act_mask;
            PAT_WALK0:  word = ~one_hot & act_mask;
            PAT_ODDEVN: word = (phase ? ~odd_bits : odd_bits) & act_mask;
            PAT_LEVEL:  word = phase ? '0 : act_mask;
            default:    word = '0;
        endcase
    end

endmodule

// File: rtl/tpg_trace_pattern.sv
// Top: muxes the pattern word onto the trace bus while a test runs, and
// passes trace_i through otherwise. Assumes a single clock domain.
module tpg_trace_pattern
    import tpg_pkg::*;
#(
    parameter  int DATA_W = 32,
    parameter  int RPT_W  = 8,
    localparam int WSEL_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [3:0]        pat_en_i,
    input  logic [WSEL_W-1:0] width_sel_i,
    input  logic [RPT_W-1:0]  repeat_i,
    input  logic              cont_i,
    input  logic [DATA_W-1:0] trace_i,
    output logic [DATA_W-1:0] data_o,
    output logic              test_active_o
);

    localparam int POS_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic              busy;
    pat_e              pat;
    logic [POS_W-1:0]  pos;
    logic              phase;
    logic [WSEL_W-1:0] width;
    logic [DATA_W-1:0] pat_word;

    tpg_seq #(.DATA_W(DATA_W), .RPT_W(RPT_W), .WSEL_W(WSEL_W), .POS_W(POS_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start_i), .en_mask(pat_en_i),
        .width_sel(width_sel_i), .rpt(repeat_i), .cont(cont_i),
        .busy(busy), .pat(pat), .pos(pos), .phase(phase), .width(width)
    );

    tpg_pat #(.DATA_W(DATA_W), .WSEL_W(WSEL_W), .POS_W(POS_W)) pat_i (
        .pat(pat), .pos(pos), .phase(phase), .width(width), .word(pat_word)
    );

    // Output select: test pattern while active, trace data otherwise.
    always_comb begin
        data_o        = busy ? pat_word : trace_i;
        test_active_o = busy;
    end

    AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (data_o >> width) == '0);                                  // R7
    AST_WALK1_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pat == PAT_WALK1) |-> $countones(data_o) == 1);            // R3
    AST_WALK0_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pat == PAT_WALK0) |-> $countones(data_o) == int'(width) - 1); // R4
    AST_ODDEVN_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pat == PAT_ODDEVN) |-> (data_o & (data_o >> 1)) == '0);    // R5
    AST_LEVEL_FULL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pat == PAT_LEVEL) |->
            (data_o == '0 || $countones(data_o) == int'(width)));           // R6

endmodule

// File: tb/tpg_trace_pattern_tb_top.sv
// Bench: behavioural reference model (queue of expected words per pass),
// compared with the outputs 2 ns after every rising edge.
module tpg_trace_pattern_tb_top;

    localparam int DW  = 32;
    localparam int RW  = 8;
    localparam int WSW = $clog2(DW + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [3:0]     pat_en_i = '0;
    logic [WSW-1:0] width_sel_i = '0;
    logic [RW-1:0]  repeat_i = '0;
    logic           cont_i = 1'b0;
    logic [DW-1:0]  trace_i = '0;
    logic [DW-1:0]  data_o;
    logic           test_active_o;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #4 clk = ~clk;

    tpg_trace_pattern #(.DATA_W(DW), .RPT_W(RW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pat_en_i(pat_en_i),
        .width_sel_i(width_sel_i), .repeat_i(repeat_i), .cont_i(cont_i),
        .trace_i(trace_i), .data_o(data_o), .test_active_o(test_active_o)
    );

    // ---------------- reference model ----------------
    logic [DW-1:0] mq[$];
    bit            m_busy = 1'b0;
    logic [3:0]    m_mask;
    int            m_rpt, m_w;

    function automatic logic [DW-1:0] pword(int p, int k, int w);
        logic [DW-1:0] am = '0;
        logic [DW-1:0] r = '0;
        for (int i = 0; i < w; i++) am[i] = 1'b1;
        case (p)
            0: r = DW'(1) << (k % w);
            1: r = am & ~(DW'(1) << (k % w));
            2: for (int i = 0; i < w; i++) r[i] = ((i % 2) == ((k % 2 == 0) ? 1 : 0));
            default: r = (k % 2 == 0) ? am : '0;
        endcase
        return r;
    endfunction

    function automatic void fill_pass();
        for (int p = 0; p < 4; p++)
            if (m_mask[p])
                for (int k = 0; k < m_rpt; k++) mq.push_back(pword(p, k, m_w));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_busy = 1'b0;
        end else if (m_busy) begin
            void'(mq.pop_front());
            if (mq.size() == 0) begin
                if (cont_i) fill_pass();
                else m_busy = 1'b0;
            end
        end else if (start_i && pat_en_i != 4'd0) begin
            m_mask = pat_en_i;
            m_rpt  = (repeat_i == 0) ? 1 : int'(repeat_i);
            m_w    = (width_sel_i == 0) ? 1 : (int'(width_sel_i) > DW ? DW : int'(width_sel_i));
            fill_pass();
            m_busy = 1'b1;
        end
    end

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            check({cur_req, " busy"}, DW'(test_active_o), DW'(m_busy));
            check({cur_req, " data"}, data_o, m_busy ? mq[0] : trace_i);
        end
    end

    // Random trace data, changed on falling edges.
    initial forever begin
        @(negedge clk);
        trace_i = {$urandom(), $urandom()};
    end

    task automatic run_test(input string req, input logic [3:0] m, input int w,
                            input int r, input bit c);
        cur_req = req;
        @(negedge clk);
        pat_en_i = m; width_sel_i = WSW'(w); repeat_i = RW'(r); cont_i = c; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (test_active_o && t < 2000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL WDOG: actual hung, expected finished run");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset busy", DW'(test_active_o), '0);
        check("R1 reset data", data_o, trace_i);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1 post-reset data", data_o, trace_i);

        cur_req = "R2"; repeat (6) @(negedge clk);                    // R2 passthrough
        run_test("R3", 4'b0001, 5, 12, 1'b0); wait_idle();            // R3 wrap at width 5
        run_test("R4", 4'b0010, 8, 10, 1'b0); wait_idle();            // R4
        run_test("R5", 4'b0100, 7, 5, 1'b0);  wait_idle();            // R5
        run_test("R6", 4'b1000, 32, 3, 1'b0); wait_idle();            // R6 full width
        run_test("R8", 4'b1111, 4, 3, 1'b0);  wait_idle();            // R8 order, R9 return
        run_test("R8", 4'b1010, 6, 0, 1'b0);  wait_idle();            // R8 skip, rpt 0 -> 1
        run_test("R9", 4'b0101, 3, 2, 1'b0);  wait_idle();            // R9

        // R10: continuous loop, then exit
        run_test("R10", 4'b0101, 3, 2, 1'b1);
        repeat (14) @(negedge clk);
        n_chk++;
        if (!test_active_o) begin
            n_fail++;
            $display("FAIL R10: actual idle, expected still looping");
        end
        cont_i = 1'b0;
        wait_idle();

        // R11: empty mask start
        run_test("R11", 4'b0000, 8, 4, 1'b0);
        #1;
        check("R11 empty mask", DW'(test_active_o), '0);
        repeat (3) @(negedge clk);

        // R12: mid-run strobes and parameter changes ignored
        run_test("R12", 4'b0011, 6, 6, 1'b0);
        repeat (3) @(negedge clk);
        pat_en_i = 4'b1100; width_sel_i = WSW'(20); repeat_i = RW'(2); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        wait_idle();

        // R7: width clamping, 0 -> 1 and 40 -> DW
        run_test("R7", 4'b0101, 0, 3, 1'b0);  wait_idle();
        run_test("R7", 4'b1011, 40, 3, 1'b0); wait_idle();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule